// File: doc/BRIEF.md
# Inverted Page Table Lookup Engine

This block translates a 32-bit virtual address into a physical address by walking an inverted page table held in on-chip storage. The table has one entry for each physical frame, and the entry's position is the frame number. A small hash anchor table, indexed by a fold of the virtual page number, gives the first frame to try. The engine compares the virtual page number stored in that frame's entry with the requested one. On a mismatch it follows the entry's link to the next candidate. The walk ends with a physical address, a miss, or a chain-overflow fault.

Requests and results travel over valid/ready interfaces. A request is taken only while `req_ready` is high, and `req_ready` is high only when the engine is idle. The result is presented on `rsp_valid` and stays frozen until `rsp_ready` is sampled high. The user can stall it for any number of cycles, and no new request is taken meanwhile. Both tables are loaded through a plain single-cycle write port. This port is meant to be used only while the engine is idle.

Top module: `ipt_lookup`

## Requirements
- R1: The anchor bucket of a request is computed in two steps. First, vpn[15:8] XOR vpn[7:0] gives an 8-bit value b, where vpn is vaddr[31:16]. The bucket is then b[7:4] XOR b[3:0].
- R2: If the anchor entry of the bucket has its valid bit (bit 6) clear, the result is status 1 (miss), presented one cycle after the accepting edge.
- R3: If the virtual page number stored in the candidate frame equals the requested one, the status is 0. The physical address is then ten zero bits, then the 6-bit frame index, then vaddr[15:0] unchanged.
- R4: Each candidate compare takes one cycle. A result reached after k link hops is presented 2+k cycles after the accepting edge.
- R5: A mismatching entry whose link-valid bit (bit 6) is clear ends the walk with status 1 (miss).
- R6: At most 16 hops are taken. A mismatch at the entry reached by the 16th hop, with its link valid, gives status 2 (chain overflow), even if the next entry would match. A match at that entry still gives status 0.
- R7: `req_ready` is high only while idle. A `req_valid` or `req_vaddr` change during a walk has no effect on the result in progress.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_paddr` and `rsp_status` hold their values. One cycle after the handshake, `rsp_valid` is low and `req_ready` is high.
- R9: On status 1 or 2, `rsp_paddr` is zero.
- R10: When `cfg_we` is high, `cfg_sel`=0 writes anchor `cfg_addr[3:0]` with {valid bit 6, frame index bits 5:0}. `cfg_sel`=1 writes frame `cfg_addr` with {vpn bits 22:7, link-valid bit 6, link index bits 5:0}. Later lookups use the new contents.
- R11: After reset, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle, request taken this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Translated address, zero on fault |
| rsp_status | output | 2 | 0 hit, 1 miss, 2 chain overflow |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | 0 anchor table, 1 frame table |
| cfg_addr | input | 6 | Entry index to write |
| cfg_wdata | input | 23 | Entry contents |

## Verification
A wrong hop counter or wrong state sequencing shows up first as `rsp_valid` rising in the wrong cycle. Because the bench checks the valid line against the computed chain length on every clock, this fault appears within one cycle of the expected result. A stale frame index or a latched address corrupted by a busy-time request shows up in `rsp_paddr` as soon as the result is presented. A response path that does not hold is caught within one stalled cycle.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {
    IPT_OK        = 2'd0,
    IPT_MISS      = 2'd1,
    IPT_CHAIN_OVF = 2'd2
  } ipt_status_e;

  typedef enum logic [1:0] {
    W_IDLE,
    W_ANCHOR,
    W_COMPARE,
    W_RESULT
  } walk_state_e;
endpackage

// File: rtl/ipt_ram.sv
module ipt_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int VPN_W  = 16,
  parameter int HASH_W = 4
) (
  input  logic [VPN_W-1:0]  vpn,
  output logic [HASH_W-1:0] bucket
);
  localparam int HALF_W = VPN_W / 2;
  localparam int SLICES = HALF_W / HASH_W;

  logic [HALF_W-1:0] folded;
  logic [HASH_W-1:0] acc [SLICES+1];

  assign folded = vpn[VPN_W-1:HALF_W] ^ vpn[HALF_W-1:0];
  assign acc[0] = '0;

  for (genvar s = 0; s < SLICES; s++) begin : g_fold
    assign acc[s+1] = acc[s] ^ folded[s*HASH_W +: HASH_W];
  end

  assign bucket = acc[SLICES];
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
  import ipt_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int OFF_W    = 16,
  parameter int FRAME_W  = 6,
  parameter int MAX_HOPS = 16,
  localparam int VPN_W   = VA_W - OFF_W,
  localparam int FRM_W   = VPN_W + FRAME_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [VA_W-1:0]    rsp_paddr,
  output logic [1:0]         rsp_status,
  output logic               anc_re,
  input  logic [FRAME_W:0]   anc_rdata,
  output logic               frm_re,
  output logic [FRAME_W-1:0] frm_raddr,
  input  logic [FRM_W-1:0]   frm_rdata
);
  localparam int HOP_W = $clog2(MAX_HOPS + 1);

  walk_state_e        state_q;
  logic [VA_W-1:0]    vaddr_q;
  logic [FRAME_W-1:0] cur_q;
  logic [HOP_W-1:0]   hops_q;
  logic [VA_W-1:0]    paddr_q;
  logic [1:0]         status_q;

  logic               a_valid, f_link_ok, f_hit, at_limit;
  logic [FRAME_W-1:0] a_idx, f_link;
  logic [VPN_W-1:0]   f_vpn;

  always_comb begin
    a_valid   = anc_rdata[FRAME_W];
    a_idx     = anc_rdata[FRAME_W-1:0];
    f_vpn     = frm_rdata[FRM_W-1:FRAME_W+1];
    f_link_ok = frm_rdata[FRAME_W];
    f_link    = frm_rdata[FRAME_W-1:0];
    f_hit     = (f_vpn == vaddr_q[VA_W-1:OFF_W]);
    at_limit  = (hops_q == HOP_W'(MAX_HOPS));
    frm_re    = ((state_q == W_ANCHOR) && a_valid) ||
                ((state_q == W_COMPARE) && !f_hit && f_link_ok && !at_limit);
    frm_raddr = (state_q == W_ANCHOR) ? a_idx : f_link;
  end

  assign req_ready  = (state_q == W_IDLE);
  assign anc_re     = req_valid && req_ready;
  assign rsp_valid  = (state_q == W_RESULT);
  assign rsp_paddr  = paddr_q;
  assign rsp_status = status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= W_IDLE;
      vaddr_q  <= '0;
      cur_q    <= '0;
      hops_q   <= '0;
      paddr_q  <= '0;
      status_q <= IPT_OK;
    end else begin
      unique case (state_q)
        W_IDLE: if (req_valid) begin
          vaddr_q <= req_vaddr;
          state_q <= W_ANCHOR;
        end
        W_ANCHOR: begin
          if (!a_valid) begin
            paddr_q  <= '0;
            status_q <= IPT_MISS;
            state_q  <= W_RESULT;
          end else begin
            cur_q   <= a_idx;
            hops_q  <= '0;
            state_q <= W_COMPARE;
          end
        end
        W_COMPARE: begin
          if (f_hit) begin
            paddr_q  <= {{(VPN_W-FRAME_W){1'b0}}, cur_q, vaddr_q[OFF_W-1:0]};
            status_q <= IPT_OK;
            state_q  <= W_RESULT;
          end else if (!f_link_ok) begin
            paddr_q  <= '0;
            status_q <= IPT_MISS;
            state_q  <= W_RESULT;
          end else if (at_limit) begin
            paddr_q  <= '0;
            status_q <= IPT_CHAIN_OVF;
            state_q  <= W_RESULT;
          end else begin
            hops_q <= hops_q + 1'b1;
            cur_q  <= f_link;
          end
        end
        W_RESULT: if (rsp_ready) state_q <= W_IDLE;
        default: state_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int VA_W     = 32,
  parameter int OFF_W    = 16,
  parameter int FRAME_W  = 6,
  parameter int HASH_W   = 4,
  parameter int MAX_HOPS = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [VA_W-1:0]               req_vaddr,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [VA_W-1:0]               rsp_paddr,
  output logic [1:0]                    rsp_status,
  input  logic                          cfg_we,
  input  logic                          cfg_sel,
  input  logic [FRAME_W-1:0]            cfg_addr,
  input  logic [VA_W-OFF_W+FRAME_W:0]   cfg_wdata
);
  localparam int VPN_W    = VA_W - OFF_W;
  localparam int ANC_W    = FRAME_W + 1;
  localparam int FRM_W    = VPN_W + FRAME_W + 1;
  localparam int NFRAMES  = 1 << FRAME_W;
  localparam int NBUCKETS = 1 << HASH_W;

  logic [HASH_W-1:0]  bucket;
  logic               anc_re, frm_re;
  logic [ANC_W-1:0]   anc_rdata;
  logic [FRAME_W-1:0] frm_raddr;
  logic [FRM_W-1:0]   frm_rdata;
  logic               unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_addr[FRAME_W-1:HASH_W], cfg_wdata[FRM_W-1:ANC_W]};

  ipt_hash #(.VPN_W(VPN_W), .HASH_W(HASH_W)) u_hash (
    .vpn    (req_vaddr[VA_W-1:OFF_W]),
    .bucket (bucket)
  );

  ipt_ram #(.DEPTH(NBUCKETS), .DW(ANC_W)) u_anchor_ram (
    .clk   (clk),
    .we    (cfg_we && !cfg_sel),
    .waddr (cfg_addr[HASH_W-1:0]),
    .wdata (cfg_wdata[ANC_W-1:0]),
    .re    (anc_re),
    .raddr (bucket),
    .rdata (anc_rdata)
  );

  ipt_ram #(.DEPTH(NFRAMES), .DW(FRM_W)) u_frame_ram (
    .clk   (clk),
    .we    (cfg_we && cfg_sel),
    .waddr (cfg_addr),
    .wdata (cfg_wdata),
    .re    (frm_re),
    .raddr (frm_raddr),
    .rdata (frm_rdata)
  );

  ipt_walker #(
    .VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .MAX_HOPS(MAX_HOPS)
  ) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_paddr  (rsp_paddr),
    .rsp_status (rsp_status),
    .anc_re     (anc_re),
    .anc_rdata  (anc_rdata),
    .frm_re     (frm_re),
    .frm_raddr  (frm_raddr),
    .frm_rdata  (frm_rdata)
  );
endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
  parameter int VA_W     = 32,
  parameter int OFF_W    = 16,
  parameter int MAX_HOPS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [OFF_W-1:0] req_off,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [VA_W-1:0]  rsp_paddr,
  input logic [1:0]       rsp_status
);
  localparam int CNT_W = $clog2(MAX_HOPS + 4) + 1;

  logic [OFF_W-1:0] off_q;
  logic [CNT_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= '0;
      wait_q <= '0;
    end else begin
      if (req_valid && req_ready) begin
        off_q  <= req_off;
        wait_q <= CNT_W'(1);
      end else if (rsp_valid) begin
        wait_q <= '0;
      end else if (wait_q != '0) begin
        wait_q <= wait_q + 1'b1;
      end
    end
  end

  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_status)));

  p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd0) |-> (rsp_paddr[OFF_W-1:0] == off_q));

  p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd0) |-> (rsp_paddr == '0));

  p_legal_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status != 2'd3));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q <= CNT_W'(MAX_HOPS + 3));
endmodule

bind ipt_lookup ipt_lookup_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .MAX_HOPS(MAX_HOPS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_off    (req_vaddr[OFF_W-1:0]),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_paddr  (rsp_paddr),
  .rsp_status (rsp_status)
);

// File: tb/ipt_lookup_tb.sv
module ipt_lookup_tb;
  localparam int NF = 64;
  localparam int NB = 16;
  localparam int HOP_LIMIT = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_status;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [22:0] cfg_wdata = '0;

  always #5 clk = ~clk;

  ipt_lookup u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_status(rsp_status),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit m_av [NB];
  int m_ai [NB];
  int m_vpn[NF];
  bit m_lv [NF];
  int m_ln [NF];

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int bucket_of(int vpn);
    int b;
    b = (vpn ^ (vpn >> 8)) & 8'hff;
    return (b ^ (b >> 4)) & 4'hf;
  endfunction

  task automatic cfg_write(bit sel, int addr, logic [22:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = addr[5:0]; cfg_wdata = data;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_anchor(int b, bit v, int idx);
    logic [5:0] ix = idx[5:0];
    m_av[b] = v; m_ai[b] = idx;
    cfg_write(1'b0, b, {16'h0000, v, ix});
  endtask

  task automatic set_frame(int f, int vpn, bit lv, int ln);
    logic [15:0] vp = vpn[15:0];
    logic [5:0]  lk = ln[5:0];
    m_vpn[f] = vpn; m_lv[f] = lv; m_ln[f] = ln;
    cfg_write(1'b1, f, {vp, lv, lk});
  endtask

  // Behavioural walk: expected status, address and delay in cycles after acceptance.
  task automatic lookup(logic [31:0] va, int hold, string rq);
    int vpn, b, idx, hops, d, st;
    logic [31:0] pa;
    logic [31:0] pa_seen;
    logic [1:0]  st_seen;
    vpn = int'(va[31:16]);
    b = bucket_of(vpn);
    pa = '0;
    if (!m_av[b]) begin
      st = 1; d = 1;
    end else begin
      idx = m_ai[b]; hops = 0;
      while (1) begin
        if (m_vpn[idx] == vpn) begin
          st = 0; d = 2 + hops;
          pa = {10'b0, idx[5:0], va[15:0]};
          break;
        end else if (!m_lv[idx]) begin
          st = 1; d = 2 + hops; break;
        end else if (hops == HOP_LIMIT) begin
          st = 2; d = 2 + hops; break;
        end else begin
          hops++; idx = m_ln[idx];
        end
      end
    end

    @(negedge clk);
    chk(req_ready, "R7", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_vaddr = va;
    @(posedge clk);
    @(negedge clk);
    req_vaddr = ~va;  // R7: change while busy, must be ignored
    for (int e = 0; e <= d; e++) begin
      if (e > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      if (e == 1) req_valid = 1'b0;
      chk(rsp_valid == (e == d), "R4", "rsp_valid timing", rsp_valid, (e == d));
      chk(!req_ready, "R7", "ready while busy", req_ready, 0);
    end
    chk(rsp_status == st[1:0], rq, "status", rsp_status, st);
    chk(rsp_paddr == pa, rq, "paddr", rsp_paddr, pa);
    pa_seen = rsp_paddr; st_seen = rsp_status;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk);
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == pa_seen && rsp_status == st_seen,
          "R8", "held result", {rsp_valid, rsp_paddr}, {1'b1, pa_seen});
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid, "R8", "valid after handshake", rsp_valid, 0);
    chk(req_ready, "R7", "ready after handshake", req_ready, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(req_ready, "R11", "reset ready", req_ready, 1);
    chk(!rsp_valid, "R11", "reset rsp_valid", rsp_valid, 0);

    for (int i = 0; i < NB; i++) set_anchor(i, 1'b0, 0);
    for (int i = 0; i < NF; i++) set_frame(i, 16'hffff, 1'b0, 0);

    // R1/R3: single-entry bucket
    set_anchor(bucket_of(16'h1234), 1'b1, 5);
    set_frame(5, 16'h1234, 1'b0, 0);
    lookup(32'h1234_abcd, 0, "R1");
    lookup(32'h1234_0000, 2, "R3");

    // Chain in bucket 3: frames 10 -> 20 -> 33
    set_anchor(bucket_of(16'h0003), 1'b1, 10);
    set_frame(10, 16'h0003, 1'b1, 20);
    set_frame(20, 16'h0102, 1'b1, 33);
    set_frame(33, 16'h1013, 1'b0, 0);
    lookup(32'h0003_ffff, 0, "R3");
    lookup(32'h0102_1111, 0, "R4");
    lookup(32'h1013_5a5a, 3, "R4");
    lookup(32'h2023_0042, 1, "R5");
    lookup(32'h2023_0042, 0, "R9");

    // Empty bucket
    lookup(32'h0009_7777, 2, "R2");

    // Long chain: frames 40..57, none holding the target
    set_anchor(bucket_of(16'h000c), 1'b1, 40);
    for (int i = 0; i < 18; i++) set_frame(40 + i, 16'h0100 + i, (i < 17), 41 + i);
    lookup(32'h000c_1234, 1, "R6");
    set_frame(56, 16'h000c, 1'b1, 57);
    lookup(32'h000c_beef, 0, "R10");
    set_frame(56, 16'h0200, 1'b1, 57);
    set_frame(57, 16'h000c, 1'b0, 0);
    lookup(32'h000c_0001, 0, "R6");

    // Rewrite anchor to an empty slot
    set_anchor(bucket_of(16'h1234), 1'b0, 5);
    lookup(32'h1234_abcd, 0, "R10");

    finish_run();
  end
endmodule